// File: doc/BRIEF.md
# Smart card receive character buffer

This block holds characters delivered by the receiver of an ISO 7816 style UART until the host collects them. The receiver presents each 8-bit character with a one-cycle write strobe. The host pulls characters with a read strobe and always gets the oldest unread one. The block keeps registered empty, full and overrun flags and an interrupt request that follows the full flag. A pulse on the receive-entry input empties the buffer. The UART raises that pulse each time its direction control switches to receive.

The block has two operating modes. In sized mode, a 3-bit length field sets the usable depth to the field value plus one, so 1 to 8 characters. A character that arrives when the buffer is full is dropped. In watermark mode, the storage always spans 8 entries and the length field becomes a level: the full flag and the interrupt are raised while more characters are held than the level. In this mode a character that finds no room replaces the most recently stored one instead of being dropped. With the level at 0 the buffer holds a single character. Any mode or level change takes effect on the next strobe.

Top module: `sc_rx_buffer`

## Requirements
- R1: After reset, empty=1, full=0, overrun=0, irq=0 and rd_data=0.
- R2: Characters are returned in arrival order. rd_data shows the oldest unread character in the cycle after the read strobe.
- R3: In sized mode (wm_mode=0) the usable depth is level+1. full is 1 exactly when the held count equals level+1, and it clears after one read.
- R4: In sized mode, a write that finds the count at level+1 or above stores nothing, sets overrun, and leaves the held characters unchanged.
- R5: In watermark mode (wm_mode=1) the storage is 8 entries. full is 1 exactly while the held count is greater than level.
- R6: In watermark mode with level=0, one character sets full. A further write replaces that character and sets overrun.
- R7: In watermark mode with level>0 and 8 characters held, a further write replaces the most recently stored character and sets overrun. The count stays at 8.
- R8: empty, full and overrun are registered. They change in the clock after the strobe that causes the change.
- R9: overrun is sticky until ovr_clr is pulsed. A new overrun event in the same cycle as ovr_clr leaves it set.
- R10: rx_enter empties the buffer and clears overrun. A write or read strobe in the same cycle is ignored.
- R11: A read while empty leaves rd_data unchanged and does not change the count.
- R12: irq always equals full.
- R13: A read and a write in the same cycle on a full buffer are both accepted: the oldest character leaves and the new one is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_enter | input | 1 | Pulse when receive mode is entered; empties the buffer |
| wr_en | input | 1 | Character strobe from the receiver |
| wr_data | input | 8 | Received character |
| rd_en | input | 1 | Host read strobe |
| rd_data | output | 8 | Oldest character, valid the cycle after rd_en |
| wm_mode | input | 1 | 0 = sized mode, 1 = watermark mode |
| level | input | 3 | Depth minus one (sized) or full level (watermark) |
| ovr_clr | input | 1 | Clears the overrun flag |
| empty | output | 1 | No unread character held |
| full | output | 1 | Full (sized) or above level (watermark) |
| overrun | output | 1 | Sticky: a character found no room |
| irq | output | 1 | Interrupt request, follows full |

## Verification
The assertions assume that every strobe is a single-cycle, glitch-free level sampled at the rising edge. They also assume that wm_mode and level are constant in any cycle in which they matter, since a change is taken up by the next strobe. Within that, any mix of reads, writes, clears and flushes in the same cycle is legal, including reads on an empty buffer and writes beyond capacity. The stimulus drives all inputs half a period away from the sampling edge. It mixes those strobes freely and reconfigures the mode and level from time to time, including while characters are held.

// File: rtl/sc_rx_buffer_pkg.sv
package sc_rx_buffer_pkg;

  // Number of characters that may be held before a write finds no room.
  function automatic int unsigned room_limit(input logic wm, input int unsigned lvl,
                                             input int unsigned depth);
    if (wm) return (lvl == 0) ? 1 : depth;
    return lvl + 1;
  endfunction

  // Full/above-level indication for a given held count.
  function automatic logic is_full(input logic wm, input int unsigned lvl,
                                   input int unsigned cnt);
    if (wm) return cnt > lvl;
    return cnt >= lvl + 1;
  endfunction

endpackage

// File: rtl/sc_rx_buffer_ctrl.sv
module sc_rx_buffer_ctrl
  import sc_rx_buffer_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int LVL_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             wr_req,
  input  logic             rd_req,
  input  logic             wm_mode,
  input  logic [LVL_W-1:0] level,
  input  logic             ovr_clr,
  output logic             do_push,
  output logic             do_over,
  output logic             do_pop,
  output logic             empty_q,
  output logic             full_q,
  output logic             overrun_q
);

  logic [CNT_W-1:0] count_q;
  logic [CNT_W-1:0] after_rd;
  logic [CNT_W-1:0] count_d;
  logic             has_room;
  logic             ovr_evt;

  assign do_pop   = rd_req && !flush && (count_q != '0);
  assign after_rd = count_q - CNT_W'(do_pop);
  assign has_room = int'(after_rd) < room_limit(wm_mode, int'(level), DEPTH);
  assign ovr_evt  = wr_req && !flush && !has_room;
  assign do_push  = wr_req && !flush && has_room;
  assign do_over  = ovr_evt && wm_mode;
  assign count_d  = flush ? '0 : after_rd + CNT_W'(do_push);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q   <= '0;
      empty_q   <= 1'b1;
      full_q    <= 1'b0;
      overrun_q <= 1'b0;
    end else begin
      count_q   <= count_d;
      empty_q   <= (count_d == '0);
      full_q    <= is_full(wm_mode, int'(level), int'(count_d));
      if (flush)        overrun_q <= 1'b0;
      else if (ovr_evt) overrun_q <= 1'b1;
      else if (ovr_clr) overrun_q <= 1'b0;
    end
  end

  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    int'(count_q) <= DEPTH);
  a_r10_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (empty_q && !overrun_q && !full_q));
  a_r9_ovr_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && !flush && !do_push) |=> overrun_q);
  a_r9_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun_q && !ovr_clr && !flush) |=> overrun_q);
  a_r11_empty_no_pop: assert property (@(posedge clk) disable iff (!rst_n)
    empty_q |-> !do_pop);

endmodule

// File: rtl/sc_rx_buffer_store.sv
module sc_rx_buffer_store #(
  parameter int DEPTH = 8,
  parameter int DW    = 8,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          do_push,
  input  logic          do_over,
  input  logic          do_pop,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data
);

  logic [DW-1:0]    mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr;
  logic [PTR_W-1:0] rd_ptr;
  logic [PTR_W-1:0] last_ptr;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  function automatic logic [PTR_W-1:0] ptr_dec(input logic [PTR_W-1:0] p);
    return (p == '0) ? PTR_W'(DEPTH - 1) : p - 1'b1;
  endfunction

  assign last_ptr = ptr_dec(wr_ptr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      rd_data <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      if (do_push) wr_ptr <= ptr_inc(wr_ptr);
      if (do_pop) begin
        rd_data <= mem[rd_ptr];
        rd_ptr  <= ptr_inc(rd_ptr);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!flush && do_push) mem[wr_ptr] <= wr_data;
    else if (!flush && do_over) mem[last_ptr] <= wr_data;
  end

  a_r11_hold_data: assert property (@(posedge clk) disable iff (!rst_n)
    !do_pop |=> $stable(rd_data));
  a_r7_over_keeps_ptr: assert property (@(posedge clk) disable iff (!rst_n)
    (do_over && !flush) |=> $stable(wr_ptr));
  a_r2_one_action: assert property (@(posedge clk) disable iff (!rst_n)
    !(do_push && do_over));

endmodule

// File: rtl/sc_rx_buffer.sv
module sc_rx_buffer #(
  parameter int DEPTH = 8,
  parameter int DW    = 8,
  localparam int LVL_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_enter,
  input  logic             wr_en,
  input  logic [DW-1:0]    wr_data,
  input  logic             rd_en,
  output logic [DW-1:0]    rd_data,
  input  logic             wm_mode,
  input  logic [LVL_W-1:0] level,
  input  logic             ovr_clr,
  output logic             empty,
  output logic             full,
  output logic             overrun,
  output logic             irq
);

  logic do_push, do_over, do_pop;

  sc_rx_buffer_ctrl #(.DEPTH(DEPTH)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .flush(rx_enter), .wr_req(wr_en), .rd_req(rd_en),
    .wm_mode(wm_mode), .level(level), .ovr_clr(ovr_clr),
    .do_push(do_push), .do_over(do_over), .do_pop(do_pop),
    .empty_q(empty), .full_q(full), .overrun_q(overrun)
  );

  sc_rx_buffer_store #(.DEPTH(DEPTH), .DW(DW)) store_i (
    .clk(clk), .rst_n(rst_n), .flush(rx_enter), .do_push(do_push),
    .do_over(do_over), .do_pop(do_pop), .wr_data(wr_data), .rd_data(rd_data)
  );

  assign irq = full;

  a_r12_irq_full: assert property (@(posedge clk) disable iff (!rst_n)
    irq == full);
  a_r8_empty_not_full: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> !full || (wm_mode == 1'b0 && 1'b0));

endmodule

// File: tb/sc_rx_buffer_tb.sv
module sc_rx_buffer_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic rx_enter = 0, wr_en = 0, rd_en = 0, wm_mode = 0, ovr_clr = 0;
  logic [7:0] wr_data = 0;
  logic [2:0] level = 0;
  logic [7:0] rd_data;
  logic empty, full, overrun, irq;

  int n_chk = 0, n_bad = 0;
  logic [7:0] mq [8];
  int mn = 0;
  logic [7:0] m_last = 0;
  logic m_ovr = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sc_rx_buffer dut_i (
    .clk(clk), .rst_n(rst_n), .rx_enter(rx_enter), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .wm_mode(wm_mode), .level(level),
    .ovr_clr(ovr_clr), .empty(empty), .full(full), .overrun(overrun), .irq(irq)
  );

  function automatic int lim(input logic wm, input int lv);
    if (!wm) return lv + 1;
    return (lv == 0) ? 1 : 8;
  endfunction

  function automatic logic exp_full(input logic wm, input int lv, input int n);
    return wm ? (n > lv) : (n > lv);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // model update applied once per clock with the inputs sampled at the edge
  task automatic model_step();
    logic ev;
    ev = 0;
    if (rx_enter) begin
      mn = 0; m_ovr = 0;
    end else begin
      if (rd_en && mn > 0) begin
        m_last = mq[0];
        for (int i = 0; i < 7; i++) mq[i] = mq[i+1];
        mn--;
      end
      if (wr_en) begin
        if (mn < lim(wm_mode, int'(level))) begin
          mq[mn] = wr_data; mn++;
        end else begin
          ev = 1;
          if (wm_mode) mq[mn-1] = wr_data;
        end
      end
      if (ev) m_ovr = 1;
      else if (ovr_clr) m_ovr = 0;
    end
  endtask

  task automatic cyc(input logic f, input logic w, input logic [7:0] d,
                     input logic r, input logic c);
    rx_enter = f; wr_en = w; wr_data = d; rd_en = r; ovr_clr = c;
    @(posedge clk);
    model_step();
    @(negedge clk);
    rx_enter = 0; wr_en = 0; rd_en = 0; ovr_clr = 0;
    chk("R8 empty", empty, mn == 0);
    chk(wm_mode ? "R5 full" : "R3 full", full, exp_full(wm_mode, int'(level), mn));
    chk("R9 overrun", overrun, m_ovr);
    chk("R12 irq", irq, full);
    chk("R2 rd_data", rd_data, m_last);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    chk("R1 empty", empty, 1); chk("R1 full", full, 0);
    chk("R1 overrun", overrun, 0); chk("R1 irq", irq, 0); chk("R1 rd_data", rd_data, 0);
    rst_n = 1;
    @(negedge clk);

    // sized mode, depth 3: fill, overflow discarded (R3, R4)
    wm_mode = 0; level = 2;
    cyc(0,1,8'h11,0,0); cyc(0,1,8'h22,0,0);
    chk("R3 not full at 2", full, 0);
    cyc(0,1,8'h33,0,0);
    chk("R3 full at depth", full, 1);
    cyc(0,1,8'h44,0,0);
    chk("R4 overrun set", overrun, 1);
    cyc(0,0,0,1,0); chk("R4 first kept", rd_data, 8'h11);
    chk("R3 full clears after one read", full, 0);
    // R13: read+write together at full
    cyc(0,1,8'h55,0,0); chk("R13 full again", full, 1);
    cyc(0,1,8'h66,1,0); chk("R13 read oldest", rd_data, 8'h22);
    chk("R13 still full", full, 1);
    // R9: sticky, then cleared
    cyc(0,0,0,0,0); chk("R9 sticky", overrun, 1);
    cyc(0,1,8'h77,0,1); chk("R9 event beats clear", overrun, 1);
    cyc(0,0,0,0,1); chk("R9 cleared", overrun, 0);
    cyc(0,0,0,1,0); chk("R4 order", rd_data, 8'h33);
    cyc(0,0,0,1,0); chk("R2 order", rd_data, 8'h55);
    cyc(0,0,0,1,0); chk("R2 order", rd_data, 8'h66);
    chk("R8 empty after drain", empty, 1);
    // R11: read on empty
    cyc(0,0,0,1,0); chk("R11 data held", rd_data, 8'h66); chk("R11 still empty", empty, 1);
    // R6: watermark level 0
    wm_mode = 1; level = 0;
    cyc(0,1,8'hA1,0,0); chk("R6 one char full", full, 1);
    cyc(0,1,8'hA2,0,0); chk("R6 overrun", overrun, 1);
    cyc(0,0,0,1,0); chk("R6 replaced", rd_data, 8'hA2); chk("R6 empty", empty, 1);
    // R10: flush ignores same-cycle write
    cyc(0,1,8'hB0,0,0);
    cyc(1,1,8'hB1,1,0); chk("R10 empty", empty, 1); chk("R10 overrun clear", overrun, 0);
    chk("R10 read ignored", rd_data, 8'hA2);
    // R7: watermark level 3, fill 8, one more replaces newest
    level = 3;
    for (int i = 0; i < 8; i++) begin
      cyc(0,1,8'hC0 + 8'(i),0,0);
      chk("R5 above level", full, (i + 1) > 3);
    end
    cyc(0,1,8'hCF,0,0); chk("R7 overrun", overrun, 1);
    for (int i = 0; i < 8; i++) begin
      cyc(0,0,0,1,0);
      chk("R7 contents", rd_data, (i == 7) ? 8'hCF : 8'hC0 + 8'(i));
      chk("R5 level drop", full, (7 - i) > 3);
    end

    // constrained random
    for (int k = 0; k < 3000; k++) begin
      if (k % 97 == 0) begin
        wm_mode = 1'($urandom % 2); level = 3'($urandom % 8);
      end
      cyc(($urandom % 100) < 2, ($urandom % 100) < 55, 8'($urandom),
          ($urandom % 100) < 45, ($urandom % 100) < 6);
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'h5C5C));
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule